// File: doc/BRIEF.md
# Configurable Serial Transmit Framer

This block turns bytes into asynchronous serial frames on a single output line. The frame shape is set by an 8-bit mode word, which selects the data length, the parity kind and the stop-bit count. The bit rate comes from a two-stage divider (a generator count and a per-bit count), with an optional fixed prescale placed in front of it. A byte is offered on a valid/ready handshake. The block then drives a low start bit, the data bits least-significant first, an optional parity bit and one or two high stop bits. The line rests high between frames.

The mode word and both divider counts are sampled when a byte is accepted, and they stay fixed for that frame. A break request holds the line low once the current frame has ended, and it lasts until a stop request arrives. A generator count of zero stops the bit-rate enable, so the block accepts nothing.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line `txd` is high and no break is active. While idle with a nonzero `gen_div`, `in_ready` is high.
- R2: A frame is sent in this order: one low start bit, the data bits least-significant bit first, the parity bit if one is used, then high stop bits.
- R3: `mode_cfg[2:1]` sets the data length. 2'b11 selects 6 bits, 2'b10 selects 7 bits, and 2'b00 or 2'b01 select 8 bits. Unused upper bits of `in_data` are not sent.
- R4: `mode_cfg[5:3]` sets parity. 3'b000 selects even parity, where the parity bit equals the XOR of the sent data bits. 3'b001 selects odd parity, the inverse of that XOR. Any other code sends no parity bit.
- R5: `mode_cfg[7:6]` sets the stop bits. 2'b11 gives one stop bit and any other code gives two.
- R6: Every bit lasts P × `gen_div` × (`bit_div` + 1) clock cycles. P is 8 when `mode_cfg[0]` is 1 and 1 when it is 0.
- R7: `in_ready` is low from the accept edge until the frame ends. It returns high exactly L × bit-period cycles after the accept edge, where L = 1 + data bits + parity bits + stop bits.
- R8: Changes to `mode_cfg`, `gen_div` or `bit_div` after a byte is accepted have no effect on that frame.
- R9: While `gen_div` is zero, `in_ready` stays low and `txd` stays high.
- R10: A `brk_set` pulse without `brk_clr`, given while idle, drives `txd` low and `in_ready` low from the next cycle. Both stay low until a `brk_clr` pulse, after which `txd` and `in_ready` are high again.
- R11: A break requested during a frame leaves that frame unchanged. The line goes low in the first cycle after the frame.
- R12: `brk_set` and `brk_clr` asserted in the same cycle do not start a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 8 | Prescale select, data length, parity and stop-bit fields |
| gen_div | input | CD_W | Generator divide count; zero disables transmission |
| bit_div | input | BD_W | Per-bit divide count, used as value plus one |
| brk_set | input | 1 | Request to start a break |
| brk_clr | input | 1 | Request to end a break |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with CD_W=4 and BD_W=3. These widths keep bit periods short, so every one of the 128 data-length, parity and stop-bit combinations can be framed at one cycle per bit. They also allow a full sweep of generator counts 1 to 3 and bit counts 0 to 2, with and without the prescale, inside a few thousand cycles per setting. Each expected bit and frame end is worked out arithmetically from the mode word and sampled at the centre of its bit period. Mid-frame configuration changes, a zero generator count and the break requests are checked at the port edges.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int CD_W     = 16,
  parameter int BD_W     = 8,
  parameter int PRESCALE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      mode_cfg,
  input  logic [CD_W-1:0] gen_div,
  input  logic [BD_W-1:0] bit_div,
  input  logic            brk_set,
  input  logic            brk_clr,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            txd
);

  localparam int PS_W = $clog2(PRESCALE);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             st;
  logic [7:0]      sh;
  logic [2:0]      last_idx, bit_idx;
  logic            par_en, two_stop, stop_idx, par_acc, pre_sel, line_q, brk_q;
  logic [CD_W-1:0] cd_q, cd_cnt;
  logic [BD_W-1:0] bd_q, bd_cnt;
  logic [PS_W-1:0] ps_cnt;
  logic            pre_tick, cd_tick, bit_tick, accept;

  assign in_ready = (st == S_IDLE) && !brk_q && (gen_div != '0);
  assign accept   = in_valid && in_ready;
  assign txd      = (st == S_IDLE) ? ~brk_q : line_q;

  assign pre_tick = !pre_sel || (ps_cnt == PS_W'(PRESCALE - 1));
  assign cd_tick  = pre_tick && (cd_cnt == cd_q - 1'b1);
  assign bit_tick = cd_tick && (bd_cnt == bd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt <= '0;
      cd_cnt <= '0;
      bd_cnt <= '0;
    end else if (st == S_IDLE) begin
      ps_cnt <= '0;
      cd_cnt <= '0;
      bd_cnt <= '0;
    end else begin
      if (pre_sel) ps_cnt <= pre_tick ? '0 : ps_cnt + 1'b1;
      if (pre_tick) cd_cnt <= cd_tick ? '0 : cd_cnt + 1'b1;
      if (cd_tick) bd_cnt <= bit_tick ? '0 : bd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_q <= 1'b0;
    else if (brk_clr) brk_q <= 1'b0;
    else if (brk_set) brk_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      last_idx <= 3'd7;
      bit_idx  <= '0;
      par_en   <= 1'b0;
      two_stop <= 1'b0;
      stop_idx <= 1'b0;
      par_acc  <= 1'b0;
      pre_sel  <= 1'b0;
      line_q   <= 1'b1;
      cd_q     <= '0;
      bd_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          sh       <= in_data;
          pre_sel  <= mode_cfg[0];
          last_idx <= (mode_cfg[2:1] == 2'b11) ? 3'd5 :
                      (mode_cfg[2:1] == 2'b10) ? 3'd6 : 3'd7;
          par_en   <= (mode_cfg[5:4] == 2'b00);
          par_acc  <= (mode_cfg[5:3] == 3'b001);
          two_stop <= (mode_cfg[7:6] != 2'b11);
          cd_q     <= gen_div;
          bd_q     <= bit_div;
          bit_idx  <= '0;
          stop_idx <= 1'b0;
          line_q   <= 1'b0;
          st       <= S_START;
        end
        S_START: if (bit_tick) begin
          line_q  <= sh[0];
          par_acc <= par_acc ^ sh[0];
          sh      <= sh >> 1;
          st      <= S_DATA;
        end
        S_DATA: if (bit_tick) begin
          if (bit_idx == last_idx) begin
            line_q <= par_en ? par_acc : 1'b1;
            st     <= par_en ? S_PAR : S_STOP;
          end else begin
            line_q  <= sh[0];
            par_acc <= par_acc ^ sh[0];
            sh      <= sh >> 1;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        S_PAR: if (bit_tick) begin
          line_q <= 1'b1;
          st     <= S_STOP;
        end
        S_STOP: if (bit_tick) begin
          line_q <= 1'b1;
          if (two_stop && !stop_idx) stop_idx <= 1'b1;
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !txd);
  assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !bit_tick) |=> $stable(txd));
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !in_ready);
  assert_cd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_div == '0) |-> !in_ready);
  assert_break_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_set && !brk_clr && st == S_IDLE) |=> (!txd && !in_ready));
  assert_break_both_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_set && brk_clr) |=> !brk_q);

endmodule

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
  localparam int CD_W = 4;
  localparam int BD_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mode_cfg = 8'hC0;
  logic [CD_W-1:0] gen_div = 4'd1;
  logic [BD_W-1:0] bit_div = '0;
  logic brk_set = 1'b0, brk_clr = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, txd;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_frame_tx #(.CD_W(CD_W), .BD_W(BD_W)) i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .gen_div(gen_div),
    .bit_div(bit_div), .brk_set(brk_set), .brk_clr(brk_clr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [7:0] m, input int cd,
                      input int bd, input bit scramble, input bit brk_mid, input string tag);
    int nd, ns, bp, len, cyc, pb;
    bit exp_b[12];
    nd = (m[2:1] == 2'b11) ? 6 : (m[2:1] == 2'b10) ? 7 : 8;
    ns = (m[7:6] == 2'b11) ? 1 : 2;
    pb = (m[5:3] == 3'b000 || m[5:3] == 3'b001) ? 1 : 0;
    bp = (m[0] ? 8 : 1) * cd * (bd + 1);
    len = 1 + nd + pb + ns;
    exp_b[0] = 1'b0;
    for (int i = 0; i < nd; i++) exp_b[1 + i] = d[i];
    if (pb == 1) begin
      bit x;
      x = (m[5:3] == 3'b001);
      for (int i = 0; i < nd; i++) x ^= d[i];
      exp_b[1 + nd] = x;
    end
    for (int i = 0; i < ns; i++) exp_b[1 + nd + pb + i] = 1'b1;
    @(negedge clk);
    mode_cfg = m; gen_div = CD_W'(cd); bit_div = BD_W'(bd); in_data = d; in_valid = 1'b1;
    #0.1;
    chk(in_ready == 1'b1, {tag, " R7 ready before accept"}, in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    if (scramble) begin
      mode_cfg = ~m; gen_div = CD_W'(cd + 1); bit_div = BD_W'(bd + 2);
    end
    if (brk_mid) begin
      brk_set = 1'b1;
      @(negedge clk); cyc++;
      brk_set = 1'b0;
    end
    for (int k = 0; k < len; k++) begin
      while (cyc < k * bp + bp / 2) begin @(negedge clk); cyc++; end
      chk(txd == exp_b[k], {tag, " frame bit"}, txd, exp_b[k]);
    end
    while (cyc < len * bp - 1) begin @(negedge clk); cyc++; end
    chk(in_ready == 1'b0, {tag, " R7 busy at last cycle"}, in_ready, 0);
    @(negedge clk);
    chk(in_ready == !brk_mid, {tag, " R7 ready at frame end"}, in_ready, !brk_mid);
    chk(txd == !brk_mid, {tag, " line after frame"}, txd, !brk_mid);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 reset line", txd, 1);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);

    for (int m = 0; m < 256; m += 2)
      send(8'((m * 37 + 5) ^ 8'h5A), 8'(m), 1, 0, 1'b0, 1'b0, "R2 R3 R4 R5");

    for (int p = 0; p < 2; p++)
      for (int cd = 1; cd <= 3; cd++)
        for (int bd = 0; bd <= 2; bd++)
          send(8'hA5 ^ 8'(cd * 3 + bd), 8'hC0 | 8'(p), cd, bd, 1'b0, 1'b0, "R6");

    send(8'h3C, 8'h42, 2, 1, 1'b1, 1'b0, "R8");
    send(8'hC3, 8'h0B, 1, 2, 1'b1, 1'b0, "R8");

    @(negedge clk);
    gen_div = '0; in_valid = 1'b1; in_data = 8'h00;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9 ready with zero divider", in_ready, 0);
      chk(txd == 1'b1, "R9 line with zero divider", txd, 1);
    end
    in_valid = 1'b0; gen_div = 4'd1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after divider restored", in_ready, 1);

    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    chk(txd == 1'b0, "R10 break starts", txd, 0);
    chk(in_ready == 1'b0, "R10 not ready in break", in_ready, 0);
    repeat (15) @(negedge clk);
    chk(txd == 1'b0, "R10 break held", txd, 0);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    chk(txd == 1'b1, "R10 break ends", txd, 1);
    chk(in_ready == 1'b1, "R10 ready after break", in_ready, 1);

    brk_set = 1'b1; brk_clr = 1'b1;
    @(negedge clk);
    brk_set = 1'b0; brk_clr = 1'b0;
    chk(txd == 1'b1, "R12 set with clear", txd, 1);
    @(negedge clk);
    chk(in_ready == 1'b1, "R12 still ready", in_ready, 1);

    send(8'h96, 8'h08, 2, 1, 1'b0, 1'b1, "R11");
    repeat (5) @(negedge clk);
    chk(txd == 1'b0, "R11 break held after frame", txd, 0);
    brk_clr = 1'b1;
    @(negedge clk);
    brk_clr = 1'b0;
    chk(txd == 1'b1, "R11 line after clear", txd, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule